// File: doc/BRIEF.md
# Boot-Time Serial EEPROM Configuration Loader

After reset this block is the only master on a two-wire serial bus that carries a single configuration EEPROM. It sets the device's word pointer to a start address, then reads every byte from there to the top of the 256-byte array in one sequential transfer. Three setting bytes and a four-byte validity tag are kept. The tag sits in the last four locations, FCh to FFh, and must hold the ASCII characters "ATA2". If it does not, or if the EEPROM fails to acknowledge, the block discards what it read and presents built-in defaults.

The settings are a media clock-limit byte at F4h and two spare bytes at F5h and F6h. The clock-limit byte holds two nibble-coded caps: the high nibble is for memory-stick media and the low nibble is for SD/MMC media. Each cap is decoded to a frequency in MHz. The bus is driven only through pull-low enables, so the pins behave as open-drain. Each SCL low phase and high phase lasts two quarter periods of `QTR_CYC` system clocks. With the default of 125 and a 50 MHz clock this gives 5 µs per phase, or 100 kbit/s. `FIRST_ADDR` sets the start address (00h by default) and must not exceed F4h.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: While reset is held, and until `done`, both pull enables are low after reset, `done` and `cfg_valid` are 0, `clk_limit` is 00h, `spare_a` is 66h, `spare_b` is 00h, `ms_clk_mhz` is 60 and `sd_clk_mhz` is 48.
- R2: The transfer runs in this order: START, then device address with R/W=0, then word address `FIRST_ADDR`, then repeated START, then device address with R/W=1, then a sequential read of locations `FIRST_ADDR` to FFh, then STOP.
- R3: SDA changes while SCL is high only to form START or STOP. A load therefore shows exactly two STARTs and one STOP.
- R4: Every SCL low phase and every SCL high phase after the first low phase lasts at least 2*`QTR_CYC` clocks.
- R5: The master drives ACK (SDA low) in the ninth bit of every read byte except the last. It leaves SDA high (NACK) in the ninth bit of the last byte.
- R6: If locations FCh..FFh read 41h,54h,41h,32h, then `cfg_valid` is 1 and `clk_limit` equals the byte read from F4h.
- R7: If any tag byte differs, then `cfg_valid` is 0 and all outputs keep their R1 default values.
- R8: If the device address is not acknowledged, the block issues STOP without a read phase, sets `done`, and presents the defaults with `cfg_valid` 0.
- R9: `ms_clk_mhz` decodes `clk_limit[7:4]` as follows: 1→40, 2→20, 3→15. Any other value (0 and 4..15) gives 60.
- R10: `sd_clk_mhz` decodes `clk_limit[3:0]` as follows: 1→24, 2→20, 3→15. Any other value (0 and 4..15) gives 48.
- R11: When the tag is valid, `spare_a` and `spare_b` equal the bytes read from F5h and F6h.
- R12: `done` and `cfg_valid` update on the same clock edge, one edge after the STOP's last quarter. From then until reset, all outputs are frozen and both lines are released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; a load starts when it is released |
| sda_in | input | 1 | Sampled level of the SDA line |
| scl_pull | output | 1 | 1 pulls SCL low |
| sda_pull | output | 1 | 1 pulls SDA low |
| done | output | 1 | Load finished |
| cfg_valid | output | 1 | Tag matched and the loaded values are in use |
| clk_limit | output | 8 | Clock-limit byte (F4h or 00h) |
| spare_a | output | 8 | Spare setting (F5h or 66h) |
| spare_b | output | 8 | Spare setting (F6h or 00h) |
| ms_clk_mhz | output | 6 | Memory-stick clock cap in MHz |
| sd_clk_mhz | output | 6 | SD/MMC clock cap in MHz |

## Verification
The line pull enables are registered, so every bus event shows up one clock after the quarter in which it is decided. The EEPROM model in the bench reacts one clock after it sees an SCL edge, and the master samples SDA at the end of the first high quarter, well after that. The decoded outputs change only on the edge that raises `done`. The bench therefore polls `done` at falling clock edges and reads every result in that same sample. It reads the results again 50 clocks later to confirm they have not moved. The reset defaults are read during reset and again 20 clocks after release, before any byte can have arrived.

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader #(
  parameter int         QTR_CYC    = 125,
  parameter logic [6:0] DEV_ADDR   = 7'h50,
  parameter logic [7:0] FIRST_ADDR = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_in,
  output logic       scl_pull,
  output logic       sda_pull,
  output logic       done,
  output logic       cfg_valid,
  output logic [7:0] clk_limit,
  output logic [7:0] spare_a,
  output logic [7:0] spare_b,
  output logic [5:0] ms_clk_mhz,
  output logic [5:0] sd_clk_mhz
);
  localparam int          TW       = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam int          LW       = TW + 4;
  localparam logic [8:0]  LAST_IDX = 9'd255 - {1'b0, FIRST_ADDR};
  localparam logic [31:0] TAG      = 32'h4154_4132;
  localparam logic [7:0]  SPA_DEF  = 8'h66;
  localparam logic [7:0]  SPB_DEF  = 8'h00;

  typedef enum logic [2:0] {
    ST_START, ST_DEVW, ST_WADR, ST_RSTART, ST_DEVR, ST_READ, ST_STOP, ST_DONE
  } st_t;

  st_t         st;
  logic [TW-1:0] tcnt;
  logic [2:0]  q;
  logic [3:0]  bitn;
  logic [7:0]  sh;
  logic [8:0]  nbyte;
  logic        nack_seen;
  logic [7:0]  lim_r, spa_r, spb_r;
  logic [31:0] tag_r;
  logic        scl_nxt, sda_nxt;

  wire is_cond   = (st == ST_START) || (st == ST_RSTART) || (st == ST_STOP);
  wire is_tx     = (st == ST_DEVW) || (st == ST_WADR) || (st == ST_DEVR);
  wire tick      = (tcnt == TW'(QTR_CYC - 1));
  wire slot_end  = tick && (q == (is_cond ? 3'd5 : 3'd3));
  wire samp      = tick && (q == 3'd2) && !is_cond;
  wire last_byte = (nbyte == LAST_IDX);
  wire [7:0] cur_addr = FIRST_ADDR + nbyte[7:0];
  wire tag_ok    = (tag_r == TAG) && !nack_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      q    <= 3'd0;
    end else if (st != ST_DONE) begin
      if (tick) begin
        tcnt <= '0;
        q    <= slot_end ? 3'd0 : q + 3'd1;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_START;
      bitn      <= 4'd0;
      sh        <= 8'h00;
      nbyte     <= 9'd0;
      nack_seen <= 1'b0;
      lim_r     <= 8'h00;
      spa_r     <= SPA_DEF;
      spb_r     <= SPB_DEF;
      tag_r     <= 32'h0;
      done      <= 1'b0;
      cfg_valid <= 1'b0;
      clk_limit <= 8'h00;
      spare_a   <= SPA_DEF;
      spare_b   <= SPB_DEF;
    end else begin
      if (samp) begin
        if (st == ST_READ && bitn != 4'd8) sh <= {sh[6:0], sda_in};
        if (is_tx && bitn == 4'd8 && sda_in) nack_seen <= 1'b1;
      end
      if (slot_end) begin
        case (st)
          ST_START: begin
            st   <= ST_DEVW;
            sh   <= {DEV_ADDR, 1'b0};
            bitn <= 4'd0;
          end
          ST_RSTART: begin
            st   <= ST_DEVR;
            sh   <= {DEV_ADDR, 1'b1};
            bitn <= 4'd0;
          end
          ST_DEVW, ST_WADR, ST_DEVR: begin
            if (bitn != 4'd8) begin
              sh   <= {sh[6:0], 1'b0};
              bitn <= bitn + 4'd1;
            end else begin
              bitn <= 4'd0;
              if (nack_seen) st <= ST_STOP;
              else begin
                case (st)
                  ST_DEVW: begin
                    st <= ST_WADR;
                    sh <= FIRST_ADDR;
                  end
                  ST_WADR: st <= ST_RSTART;
                  default: st <= ST_READ;
                endcase
              end
            end
          end
          ST_READ: begin
            if (bitn == 4'd7) begin
              case (cur_addr)
                8'hF4: lim_r <= sh;
                8'hF5: spa_r <= sh;
                8'hF6: spb_r <= sh;
                8'hFC: tag_r[31:24] <= sh;
                8'hFD: tag_r[23:16] <= sh;
                8'hFE: tag_r[15:8]  <= sh;
                8'hFF: tag_r[7:0]   <= sh;
                default: ;
              endcase
            end
            if (bitn != 4'd8) bitn <= bitn + 4'd1;
            else if (last_byte) st <= ST_STOP;
            else begin
              bitn  <= 4'd0;
              nbyte <= nbyte + 9'd1;
            end
          end
          ST_STOP: begin
            st        <= ST_DONE;
            done      <= 1'b1;
            cfg_valid <= tag_ok;
            clk_limit <= tag_ok ? lim_r : 8'h00;
            spare_a   <= tag_ok ? spa_r : SPA_DEF;
            spare_b   <= tag_ok ? spb_r : SPB_DEF;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    scl_nxt = 1'b0;
    sda_nxt = sda_pull;
    case (st)
      ST_START, ST_RSTART: begin
        scl_nxt = (q < 3'd2);
        if (q != 3'd0) sda_nxt = (q >= 3'd4);
      end
      ST_STOP: begin
        scl_nxt = (q < 3'd2);
        if (q != 3'd0) sda_nxt = (q < 3'd4);
      end
      ST_DEVW, ST_WADR, ST_DEVR: begin
        scl_nxt = (q < 3'd2);
        if (q != 3'd0) sda_nxt = (bitn != 4'd8) && !sh[7];
      end
      ST_READ: begin
        scl_nxt = (q < 3'd2);
        if (q != 3'd0) sda_nxt = (bitn == 4'd8) && !last_byte;
      end
      default: sda_nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pull <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      scl_pull <= scl_nxt;
      sda_pull <= sda_nxt;
    end
  end

  always_comb begin
    case (clk_limit[7:4])
      4'd1:    ms_clk_mhz = 6'd40;
      4'd2:    ms_clk_mhz = 6'd20;
      4'd3:    ms_clk_mhz = 6'd15;
      default: ms_clk_mhz = 6'd60;
    endcase
    case (clk_limit[3:0])
      4'd1:    sd_clk_mhz = 6'd24;
      4'd2:    sd_clk_mhz = 6'd20;
      4'd3:    sd_clk_mhz = 6'd15;
      default: sd_clk_mhz = 6'd48;
    endcase
  end

  logic          scl_q, seen_low;
  logic [LW-1:0] lvl_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b0;
      seen_low <= 1'b0;
      lvl_cnt  <= '0;
    end else begin
      scl_q    <= scl_pull;
      seen_low <= seen_low | scl_pull;
      if (scl_pull != scl_q) lvl_cnt <= LW'(1);
      else if (lvl_cnt != '1) lvl_cnt <= lvl_cnt + 1'b1;
    end
  end

  p_sda_cond_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pull && !scl_q && (sda_pull != $past(sda_pull))) |-> $past(is_cond));

  p_scl_low_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && !scl_pull) |-> (int'(lvl_cnt) >= 2 * QTR_CYC));

  p_scl_high_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_low && !scl_q && scl_pull) |-> (int'(lvl_cnt) >= 2 * QTR_CYC));

  p_valid_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> done);

  p_defaults_when_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_valid) |-> (clk_limit == 8'h00 && spare_a == SPA_DEF && spare_b == SPB_DEF));

  p_no_read_after_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_READ) |-> !nack_seen);

  p_frozen_after_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && $stable(cfg_valid) && $stable(clk_limit) && $stable(spare_a) && $stable(spare_b)));

  p_lines_free_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!scl_pull && !sda_pull));

endmodule

// File: tb/cfg_eeprom_loader_tb.sv
`timescale 1ns/1ps
module cfg_eeprom_loader_tb_top;
  localparam int          Q     = 2;
  localparam logic [6:0]  DEV   = 7'h50;
  localparam logic [7:0]  FIRST = 8'hF4;
  localparam int          NB    = 256 - int'(FIRST);
  localparam logic [31:0] TAG   = 32'h4154_4132;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_pull, sda_pull, done, cfg_valid;
  logic [7:0] clk_limit, spare_a, spare_b;
  logic [5:0] ms_clk_mhz, sd_clk_mhz;
  logic slv_drv;
  wire scl = !scl_pull;
  wire sda = !(sda_pull || slv_drv);

  cfg_eeprom_loader #(.QTR_CYC(Q), .DEV_ADDR(DEV), .FIRST_ADDR(FIRST)) dut_i (
    .clk(clk), .rst_n(rst_n), .sda_in(sda),
    .scl_pull(scl_pull), .sda_pull(sda_pull),
    .done(done), .cfg_valid(cfg_valid),
    .clk_limit(clk_limit), .spare_a(spare_a), .spare_b(spare_b),
    .ms_clk_mhz(ms_clk_mhz), .sd_clk_mhz(sd_clk_mhz)
  );

  // EEPROM model
  typedef enum logic [2:0] {M_IDLE, M_ADDR, M_WADR, M_WAIT, M_RD} mst_t;
  logic [7:0] mem [256];
  logic [6:0] slv_addr;
  mst_t ms;
  logic ps, pd, rw, mack;
  int   bc;
  logic [7:0] sr, ptr, waddr_seen;
  int n_start, n_stop, n_ack, n_nack, n_rd, n_served, n_anack;

  always @(posedge clk) begin
    if (!rst_n) begin
      ms <= M_IDLE; ps <= 1'b1; pd <= 1'b1; bc <= 0; sr <= 8'h00; ptr <= 8'h00;
      slv_drv <= 1'b0; rw <= 1'b0; mack <= 1'b0; waddr_seen <= 8'h00;
      n_start <= 0; n_stop <= 0; n_ack <= 0; n_nack <= 0; n_rd <= 0; n_served <= 0; n_anack <= 0;
    end else begin
      ps <= scl;
      pd <= sda;
      if (ps && scl && pd && !sda) begin
        n_start <= n_start + 1; ms <= M_ADDR; bc <= 0; slv_drv <= 1'b0;
      end else if (ps && scl && !pd && sda) begin
        n_stop <= n_stop + 1; ms <= M_IDLE; slv_drv <= 1'b0;
      end else if (!ps && scl) begin
        bc <= bc + 1;
        if (bc < 8) sr <= {sr[6:0], sda};
        if (ms == M_RD && bc == 8) begin
          mack <= !sda;
          if (sda) n_nack <= n_nack + 1; else n_ack <= n_ack + 1;
        end
      end else if (ps && !scl) begin
        case (ms)
          M_ADDR:
            if (bc == 8) begin
              if (sr[7:1] == slv_addr) begin slv_drv <= 1'b1; rw <= sr[0]; end
              else begin ms <= M_IDLE; n_anack <= n_anack + 1; end
            end else if (bc == 9) begin
              bc <= 0;
              if (rw) begin ms <= M_RD; slv_drv <= !mem[ptr][7]; n_rd <= n_rd + 1; end
              else begin ms <= M_WADR; slv_drv <= 1'b0; end
            end
          M_WADR:
            if (bc == 8) begin slv_drv <= 1'b1; ptr <= sr; waddr_seen <= sr; end
            else if (bc == 9) begin slv_drv <= 1'b0; ms <= M_WAIT; end
          M_RD:
            if (bc >= 1 && bc <= 7) slv_drv <= !mem[ptr][7-bc];
            else if (bc == 8) slv_drv <= 1'b0;
            else if (bc == 9) begin
              n_served <= n_served + 1;
              if (mack) begin ptr <= ptr + 8'd1; bc <= 0; slv_drv <= !mem[8'(ptr + 8'd1)][7]; end
              else begin slv_drv <= 1'b0; ms <= M_IDLE; end
            end
          default: ;
        endcase
      end
    end
  end

  // SCL phase length monitor
  logic plev, seen_lo;
  int   len, min_lo, min_hi;
  always @(posedge clk) begin
    if (!rst_n) begin
      plev <= scl; seen_lo <= 1'b0; len <= 0; min_lo <= 1000000; min_hi <= 1000000;
    end else if (scl != plev) begin
      if (!plev) begin
        if (len < min_lo) min_lo <= len;
        seen_lo <= 1'b1;
      end else if (seen_lo && len < min_hi) min_hi <= len;
      len  <= 1;
      plev <= scl;
    end else begin
      len <= len + 1;
    end
  end

  int checks = 0, fails = 0;
  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ms_exp(input int n);
    case (n) 1: return 40; 2: return 20; 3: return 15; default: return 60; endcase
  endfunction
  function automatic int sd_exp(input int n);
    case (n) 1: return 24; 2: return 20; 3: return 15; default: return 48; endcase
  endfunction

  task automatic run_load(input logic [6:0] sa, input logic [7:0] b4, input logic [7:0] b5,
                          input logic [7:0] b6, input logic [31:0] tag);
    bit acked, valid;
    int n;
    logic [7:0] lim0;
    for (int a = 0; a < 256; a++) mem[a] = 8'(a * 7 + 1);
    mem[8'hF4] = b4; mem[8'hF5] = b5; mem[8'hF6] = b6;
    mem[8'hFC] = tag[31:24]; mem[8'hFD] = tag[23:16]; mem[8'hFE] = tag[15:8]; mem[8'hFF] = tag[7:0];
    slv_addr = sa;
    acked = (sa == DEV);
    valid = acked && (tag == TAG);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 scl_pull in reset", scl_pull, 0);
    chk("R1 sda_pull in reset", sda_pull, 0);
    chk("R1 done in reset", done, 0);
    chk("R1 cfg_valid in reset", cfg_valid, 0);
    chk("R1 clk_limit in reset", clk_limit, 0);
    chk("R1 spare_a in reset", spare_a, 8'h66);
    chk("R1 spare_b in reset", spare_b, 0);
    chk("R1 ms_clk_mhz in reset", ms_clk_mhz, 60);
    chk("R1 sd_clk_mhz in reset", sd_clk_mhz, 48);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R12 done low mid-load", done, 0);
    chk("R1 clk_limit default mid-load", clk_limit, 0);
    chk("R1 spare_a default mid-load", spare_a, 8'h66);
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk("R12 done reached", done, 1);
    chk("R12 cfg_valid with done", cfg_valid, valid);
    chk("R3 start count", n_start, acked ? 2 : 1);
    chk("R3 stop count", n_stop, 1);
    chk("R4 min SCL low", (min_lo >= 2 * Q) ? 1 : 0, 1);
    chk("R4 min SCL high", (min_hi >= 2 * Q) ? 1 : 0, 1);
    if (acked) begin
      chk("R2 word address", waddr_seen, FIRST);
      chk("R2 read phases", n_rd, 1);
      chk("R2 bytes served", n_served, NB);
      chk("R5 master acks", n_ack, NB - 1);
      chk("R5 master nacks", n_nack, 1);
    end else begin
      chk("R8 address nack seen", n_anack, 1);
      chk("R8 no read phase", n_rd, 0);
      chk("R8 no bytes served", n_served, 0);
    end
    if (valid) begin
      chk("R6 clk_limit loaded", clk_limit, b4);
      chk("R11 spare_a loaded", spare_a, b5);
      chk("R11 spare_b loaded", spare_b, b6);
      chk("R9 ms decode", ms_clk_mhz, ms_exp(int'(b4[7:4])));
      chk("R10 sd decode", sd_clk_mhz, sd_exp(int'(b4[3:0])));
    end else begin
      chk("R7 clk_limit default", clk_limit, 0);
      chk("R7 spare_a default", spare_a, 8'h66);
      chk("R7 spare_b default", spare_b, 0);
      chk("R7 ms default", ms_clk_mhz, 60);
      chk("R7 sd default", sd_clk_mhz, 48);
    end
    lim0 = clk_limit;
    repeat (50) @(negedge clk);
    chk("R12 done held", done, 1);
    chk("R12 valid held", cfg_valid, valid);
    chk("R12 clk_limit held", clk_limit, lim0);
    chk("R12 SCL released", scl, 1);
    chk("R12 SDA released", sda, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++)
      run_load(DEV, {i[3:0], 4'(15 - i)}, 8'(i * 17 + 3), 8'(~i), TAG);
    for (int k = 0; k < 4; k++)
      run_load(DEV, 8'h21, 8'h5A, 8'hC3, TAG ^ (32'h1 << (8 * k)));
    run_load(7'h51, 8'h12, 8'h77, 8'h88, TAG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule